// File: doc/BRIEF.md
# Memory ECC Error Capture Unit

This block sits next to a memory wrapper and records the ECC error events that the wrapper's read path reports. Each event is a one-cycle pulse marking either a corrected single-bit error or an uncorrectable double-bit error. The pulse arrives with the faulting word address and a flag that names the requesting master: the processor or a DMA engine. Both masters are recorded in the same way. A read of a word with no valid check bits, such as an erased word, reaches this block as an uncorrectable pulse from the wrapper.

Software reaches the unit through a small word-addressed register bus. There is a control register that holds a 4-bit enable key and a status register with write-one-to-clear flags. There are also two captured-address registers, one for uncorrectable errors and one for correctable errors. The uncorrectable address register locks on the first error it captures. Later uncorrectable errors are dropped until software reads that register. The intended service order is: clear the flag, then read the address. A level output reports a pending uncorrectable error to the system error monitor.

Top module: `ecc_err_capture`

## Requirements
- R1: When enabled and not frozen, an uncorrectable pulse sets status bit 8 on the next clock edge. The status register is at word offset 1.
- R2: Status flags are write-one-to-clear. Writing 1 to bit 8 clears the uncorrectable flag, and writing 1 to bit 0 clears the correctable flag. A 0 in either position leaves that flag unchanged.
- R3: An accepted uncorrectable pulse loads the register at word offset 2 and freezes it. Bits [AW-1:0] take the address, bit 31 takes the master (0 = processor, 1 = DMA), and the other bits read 0.
- R4: While the register is frozen, uncorrectable pulses set neither the flag nor the address. A bus read of offset 2 releases the freeze.
- R5: Pulses from a DMA master are handled exactly like pulses from the processor.
- R6: Detection is enabled only while control bits [3:0] equal 0xA. Any other value, including the reset value 0, causes every pulse to be ignored: no flag, no address capture, no error output.
- R7: The control register at word offset 0 reads back the last value written to it.
- R8: If a clear of bit 8 and an accepted uncorrectable pulse fall in the same cycle, the flag stays set.
- R9: A correctable pulse sets status bit 0 and loads the register at word offset 3 with the same layout as R3. That register is overwritten on every correctable pulse and never freezes.
- R10: `err_irq` is high exactly while status bit 8 is set. Correctable errors never raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_sbe | input | 1 | Correctable error pulse |
| evt_dbe | input | 1 | Uncorrectable error pulse |
| evt_addr | input | AW | Faulting word address |
| evt_dma | input | 1 | Requesting master: 0 processor, 1 DMA |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_off | input | 2 | Register word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid during the access cycle |
| err_irq | output | 1 | Uncorrectable error level to the error monitor |

## Verification
Suppose the freeze state is stuck set. The first accepted error is still captured, but after the address read the next uncorrectable pulse brings no flag and no new address. That shows up one cycle after the pulse. Suppose instead the freeze is stuck clear. A second pulse overwrites the captured address, which the following offset-2 read exposes. A bad key compare or a wrong clear priority shows up in `err_irq` and status bit 8 on the edge after the stimulus.

// File: rtl/ecc_cap_pkg.sv
package ecc_cap_pkg;
  localparam int DW = 32;
  localparam int OFFW = 2;
  localparam logic [OFFW-1:0] OFF_CTRL = 2'd0;
  localparam logic [OFFW-1:0] OFF_STAT = 2'd1;
  localparam logic [OFFW-1:0] OFF_UADR = 2'd2;
  localparam logic [OFFW-1:0] OFF_CADR = 2'd3;
  localparam logic [3:0] EN_KEY = 4'hA;
  localparam int UNC_BIT = 8;
  localparam int COR_BIT = 0;

  function automatic logic key_match(input logic [DW-1:0] ctrl);
    return ctrl[3:0] == EN_KEY;
  endfunction

  function automatic logic [DW-1:0] stat_word(input logic unc, input logic cor);
    logic [DW-1:0] w;
    w = '0;
    w[UNC_BIT] = unc;
    w[COR_BIT] = cor;
    return w;
  endfunction
endpackage

// File: rtl/ecc_cap_regif.sv
module ecc_cap_regif
  import ecc_cap_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_sel,
  input  logic            bus_wr,
  input  logic [OFFW-1:0] bus_off,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   ctrl_q,
  output logic            key_ok,
  output logic            clr_unc,
  output logic            clr_cor,
  output logic            rd_unc
);
  logic wr_ctrl, wr_stat;

  assign wr_ctrl = bus_sel && bus_wr && (bus_off == OFF_CTRL);
  assign wr_stat = bus_sel && bus_wr && (bus_off == OFF_STAT);
  assign rd_unc  = bus_sel && !bus_wr && (bus_off == OFF_UADR);
  assign clr_unc = wr_stat && bus_wdata[UNC_BIT];
  assign clr_cor = wr_stat && bus_wdata[COR_BIT];
  assign key_ok  = key_match(ctrl_q);

  always_ff @(posedge clk) begin
    if (!rst_n) ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= bus_wdata;
  end
endmodule

// File: rtl/ecc_unc_capture.sv
module ecc_unc_capture #(
  parameter int AW = 24
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en,
  input  logic        evt,
  input  logic [AW-1:0] addr,
  input  logic        dma,
  input  logic        clr,
  input  logic        release_rd,
  output logic        flag,
  output logic        frozen,
  output logic [AW:0] addr_q,
  output logic        capture
);
  assign capture = en && evt && !frozen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag   <= 1'b0;
      frozen <= 1'b0;
      addr_q <= '0;
    end else begin
      if (capture) flag <= 1'b1;
      else if (clr) flag <= 1'b0;
      if (capture) begin
        frozen <= 1'b1;
        addr_q <= {dma, addr};
      end else if (release_rd) begin
        frozen <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ecc_cor_capture.sv
module ecc_cor_capture #(
  parameter int AW = 24
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en,
  input  logic        evt,
  input  logic [AW-1:0] addr,
  input  logic        dma,
  input  logic        clr,
  output logic        flag,
  output logic [AW:0] addr_q
);
  logic hit;
  assign hit = en && evt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag   <= 1'b0;
      addr_q <= '0;
    end else begin
      if (hit) begin
        flag   <= 1'b1;
        addr_q <= {dma, addr};
      end else if (clr) begin
        flag <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ecc_err_capture.sv
module ecc_err_capture
  import ecc_cap_pkg::*;
#(
  parameter int AW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          evt_sbe,
  input  logic          evt_dbe,
  input  logic [AW-1:0] evt_addr,
  input  logic          evt_dma,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [1:0]    bus_off,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          err_irq
);
  localparam int PAD = DW - 1 - AW;

  logic [DW-1:0] ctrl_q;
  logic key_ok, clr_unc, clr_cor, rd_unc;
  logic unc_flag, unc_frozen, unc_capture, cor_flag;
  logic [AW:0] unc_addr_q, cor_addr_q;

  function automatic logic [DW-1:0] addr_word(input logic [AW:0] a);
    return {a[AW], {PAD{1'b0}}, a[AW-1:0]};
  endfunction

  ecc_cap_regif u_regif (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_off(bus_off), .bus_wdata(bus_wdata), .ctrl_q(ctrl_q),
    .key_ok(key_ok), .clr_unc(clr_unc), .clr_cor(clr_cor), .rd_unc(rd_unc)
  );

  ecc_unc_capture #(.AW(AW)) u_unc (
    .clk(clk), .rst_n(rst_n), .en(key_ok), .evt(evt_dbe), .addr(evt_addr),
    .dma(evt_dma), .clr(clr_unc), .release_rd(rd_unc), .flag(unc_flag),
    .frozen(unc_frozen), .addr_q(unc_addr_q), .capture(unc_capture)
  );

  ecc_cor_capture #(.AW(AW)) u_cor (
    .clk(clk), .rst_n(rst_n), .en(key_ok), .evt(evt_sbe), .addr(evt_addr),
    .dma(evt_dma), .clr(clr_cor), .flag(cor_flag), .addr_q(cor_addr_q)
  );

  always_comb begin
    case (bus_off)
      OFF_CTRL: bus_rdata = ctrl_q;
      OFF_STAT: bus_rdata = stat_word(unc_flag, cor_flag);
      OFF_UADR: bus_rdata = addr_word(unc_addr_q);
      default:  bus_rdata = addr_word(cor_addr_q);
    endcase
  end

  assign err_irq = unc_flag;
endmodule

// File: rtl/ecc_err_capture_chk.sv
module ecc_err_capture_chk #(
  parameter int AW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          key_ok,
  input logic          evt_dbe,
  input logic [AW-1:0] evt_addr,
  input logic          unc_frozen,
  input logic          unc_flag,
  input logic [AW:0]   unc_addr_q,
  input logic          rd_unc,
  input logic          clr_unc,
  input logic          err_irq
);
  AST_KEY_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (!key_ok && !unc_flag) |=> !unc_flag); // R6
  AST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (key_ok && evt_dbe && !unc_frozen) |=> (unc_flag && unc_frozen && unc_addr_q[AW-1:0] == $past(evt_addr))); // R3
  AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (unc_frozen && !rd_unc) |=> $stable(unc_addr_q)); // R4
  AST_FREEZE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_unc && !(key_ok && evt_dbe && !unc_frozen)) |=> !unc_frozen); // R4
  AST_EVENT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (key_ok && evt_dbe && !unc_frozen && clr_unc) |=> unc_flag); // R8
  AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_irq) |-> $past(key_ok && evt_dbe && !unc_frozen)); // R10
endmodule

bind ecc_err_capture ecc_err_capture_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .key_ok(key_ok), .evt_dbe(evt_dbe),
  .evt_addr(evt_addr), .unc_frozen(unc_frozen), .unc_flag(unc_flag),
  .unc_addr_q(unc_addr_q), .rd_unc(rd_unc), .clr_unc(clr_unc), .err_irq(err_irq)
);

// File: tb/tb_ecc_err_capture.sv
module tb_ecc_err_capture;
  localparam int AW = 24;
  logic clk = 1'b0, rst_n = 1'b0;
  logic evt_sbe = 0, evt_dbe = 0, evt_dma = 0;
  logic [AW-1:0] evt_addr = '0;
  logic bus_sel = 0, bus_wr = 0;
  logic [1:0] bus_off = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic err_irq;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ecc_err_capture #(.AW(AW)) dut (.*);

  function automatic logic [31:0] exp_addr(input logic dma, input logic [AW-1:0] a);
    logic [31:0] w;
    w = 32'(a);
    w[31] = dma;
    return w;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] off, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_off = off; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic bus_read(input logic [1:0] off, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_off = off;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 0;
  endtask

  task automatic pulse(input logic dbe, input logic dma, input logic [AW-1:0] a);
    @(negedge clk);
    evt_dbe = dbe; evt_sbe = !dbe; evt_dma = dma; evt_addr = a;
    @(negedge clk);
    evt_dbe = 0; evt_sbe = 0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    bus_read(2'd0, d); check("R6 reset ctrl", d, 32'h0);
    bus_read(2'd1, d); check("R1 reset status", d, 32'h0);
    check("R10 reset irq", 32'(err_irq), 32'h0);
  endtask

  task automatic t_disabled();
    logic [31:0] d;
    pulse(1, 0, 24'h00_1111);
    pulse(0, 0, 24'h00_2222);
    bus_read(2'd1, d); check("R6 key 0 status", d, 32'h0);
    check("R6 key 0 irq", 32'(err_irq), 32'h0);
    bus_write(2'd0, 32'h0000_0005);
    pulse(1, 1, 24'h00_3333);
    bus_read(2'd1, d); check("R6 key 5 status", d, 32'h0);
    bus_read(2'd2, d); check("R6 no capture", d, 32'h0);
  endtask

  task automatic t_basic();
    logic [31:0] d;
    bus_write(2'd0, 32'h000A_000A);
    bus_read(2'd0, d); check("R7 ctrl readback", d, 32'h000A_000A);
    pulse(1, 0, 24'h12_3456);
    check("R10 irq high", 32'(err_irq), 32'h1);
    bus_read(2'd1, d); check("R1 status bit8", d, 32'h100);
    bus_write(2'd1, 32'h0);
    bus_read(2'd1, d); check("R2 zero write keeps", d, 32'h100);
    bus_write(2'd1, 32'h100);
    bus_read(2'd1, d); check("R2 w1c bit8", d, 32'h0);
    check("R10 irq low", 32'(err_irq), 32'h0);
    bus_read(2'd2, d); check("R3 captured addr", d, exp_addr(0, 24'h12_3456));
  endtask

  task automatic t_freeze();
    logic [31:0] d;
    pulse(1, 0, 24'h00_0A0A);
    bus_write(2'd1, 32'h100);
    pulse(1, 0, 24'h00_0B0B);
    bus_read(2'd1, d); check("R4 frozen no flag", d, 32'h0);
    check("R4 frozen no irq", 32'(err_irq), 32'h0);
    bus_read(2'd2, d); check("R4 frozen addr", d, exp_addr(0, 24'h00_0A0A));
    pulse(1, 0, 24'h00_0C0C);
    bus_read(2'd1, d); check("R4 released flag", d, 32'h100);
    bus_write(2'd1, 32'h100);
    bus_read(2'd2, d); check("R4 released addr", d, exp_addr(0, 24'h00_0C0C));
  endtask

  task automatic t_dma();
    logic [31:0] d;
    pulse(1, 1, 24'hFF_FFFE);
    bus_read(2'd1, d); check("R5 dma flag", d, 32'h100);
    check("R5 dma irq", 32'(err_irq), 32'h1);
    bus_write(2'd1, 32'h100);
    bus_read(2'd2, d); check("R5 dma addr", d, exp_addr(1, 24'hFF_FFFE));
  endtask

  task automatic t_correctable();
    logic [31:0] d;
    pulse(0, 0, 24'h00_0010);
    pulse(0, 1, 24'h00_0020);
    bus_read(2'd1, d); check("R9 cor flag", d, 32'h1);
    check("R9 cor no irq", 32'(err_irq), 32'h0);
    bus_read(2'd3, d); check("R9 cor overwrite", d, exp_addr(1, 24'h00_0020));
    pulse(1, 0, 24'h00_0030);
    bus_write(2'd1, 32'h1);
    bus_read(2'd1, d); check("R2 clear bit0 only", d, 32'h100);
    bus_write(2'd1, 32'h100);
    bus_read(2'd2, d);
  endtask

  task automatic t_collide();
    logic [31:0] d;
    pulse(1, 0, 24'h00_0040);
    bus_read(2'd2, d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_off = 2'd1; bus_wdata = 32'h100;
    evt_dbe = 1; evt_dma = 0; evt_addr = 24'h00_0050;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0; evt_dbe = 0;
    bus_read(2'd1, d); check("R8 event beats clear", d, 32'h100);
    bus_read(2'd2, d); check("R8 addr", d, exp_addr(0, 24'h00_0050));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_disabled();
    t_basic();
    t_freeze();
    t_dma();
    t_correctable();
    t_collide();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule